// File: doc/BRIEF.md
# Sum-of-Products Logic Array

This block is a configurable two-level logic array. Its AND plane forms product terms from the true and complemented forms of the inputs. Its OR plane combines those terms into outputs, and one term can feed any number of outputs. The pattern of connections in both planes is called the personality. It is held in internal registers and loaded one product-term row at a time.

Each row write carries the AND-plane cells for one term together with the set of outputs that the term drives. The outputs are a purely combinational function of the present inputs and the stored personality. A user resets the block, writes every row that it needs, and then reads the outputs as ordinary combinational logic. Because the personality can be rewritten at any time, the same hardware can hold a different function after a later series of writes.

The default size is 3 inputs, 5 product terms and 4 outputs.

Top module: `sop_logic_array`

## Requirements
- R1: Reset clears every AND-plane cell to code 00 and every OR-plane connection to 0, so all outputs read 0 after reset for every input value.
- R2: AND-plane cells are 2 bits wide, and input i sits at bits [2i+1:2i] of the row. The codes are: 10 uses the input true, 01 uses it complemented, 00 leaves it out of the term, and 11 forces the whole term to 0.
- R3: A product term whose cells are all 00 evaluates to 1.
- R4: Output k is the OR of every term whose OR-plane bit k is 1. An output with no connected term reads 0.
- R5: A single product term drives every output whose bit it sets, so one term can feed several outputs at once.
- R6: A write with wr_en high stores wr_and and wr_or into row wr_row at the rising clock edge. Outputs show the old personality before that edge and the new one after it. While wr_en is low, the personality does not change.
- R7: A write with wr_row at or above the number of terms is ignored, and the outputs stay as they were.
- R8: Loading the terms AB, B'C, AC', B'C' and A into rows 0 to 4 gives F0 = A + B'C', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C + A. Here A, B and C are in_vec[0], in_vec[1] and in_vec[2], and Fk is f_out[k].
- R9: The outputs follow a change of in_vec without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the personality registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store one row at the next rising edge |
| wr_row | input | ROW_W | Index of the product term to write |
| wr_and | input | 2*N_IN | AND-plane cells of the row, 2 bits per input |
| wr_or | input | N_OUT | Outputs driven by the row's term |
| in_vec | input | N_IN | Logic inputs |
| f_out | output | N_OUT | Sum-of-products outputs |

## Verification
On every cycle, the assertions check the local laws of the planes. An all-open term is true, a term that holds a forcing cell is false, an output with an empty column is low, and a true term raises every output it connects to. They also check that the outputs cannot move without an input change or an in-range write, and that they read 0 just after reset. Whether whole functions are correct, such as the shared-term example, the cycle in which a write becomes visible, and the randomized personalities, can only be shown by the bench. It does this by comparing against its own model of the array.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [1:0] {
        CELL_OPEN = 2'b00,
        CELL_NEG  = 2'b01,
        CELL_POS  = 2'b10,
        CELL_KILL = 2'b11
    } cell_e;

    // Contribution of one AND-plane cell to its product term.
    function automatic logic cell_pass(input logic [1:0] code, input logic x);
        logic r;
        case (cell_e'(code))
            CELL_OPEN: r = 1'b1;
            CELL_NEG:  r = ~x;
            CELL_POS:  r = x;
            CELL_KILL: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sop_pers_store.sv
module sop_pers_store #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4,
    parameter int ROW_W  = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ROW_W-1:0]                   wr_row,
    input  logic [2*N_IN-1:0]                  wr_and,
    input  logic [N_OUT-1:0]                   wr_or,
    output logic [N_TERM-1:0][2*N_IN-1:0]      and_pers,
    output logic [N_TERM-1:0][N_OUT-1:0]       or_pers
);
    localparam int AW = 2 * N_IN;

    for (genvar t = 0; t < N_TERM; t++) begin : g_row
        logic          hit;
        logic [AW-1:0] and_q;
        logic [N_OUT-1:0] or_q;

        // Rows at or above N_TERM never match, so their writes are dropped.
        assign hit = wr_en && (wr_row == ROW_W'(t));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                and_q <= '0;
                or_q  <= '0;
            end else if (hit) begin
                and_q <= wr_and;
                or_q  <= wr_or;
            end
        end

        assign and_pers[t] = and_q;
        assign or_pers[t]  = or_q;
    end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5
) (
    input  logic [N_IN-1:0]                    in_vec,
    input  logic [N_TERM-1:0][2*N_IN-1:0]      and_pers,
    output logic [N_TERM-1:0]                  term_vec
);
    import sop_pkg::*;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic acc;
        always_comb begin
            acc = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                acc = acc & cell_pass(and_pers[t][2*i +: 2], in_vec[i]);
            end
        end
        assign term_vec[t] = acc;
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4
) (
    input  logic [N_TERM-1:0]                  term_vec,
    input  logic [N_TERM-1:0][N_OUT-1:0]       or_pers,
    output logic [N_OUT-1:0]                   f_out
);
    for (genvar k = 0; k < N_OUT; k++) begin : g_sum
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int t = 0; t < N_TERM; t++) begin
                acc = acc | (term_vec[t] & or_pers[t][k]);
            end
        end
        assign f_out[k] = acc;
    end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4,
    localparam int ROW_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ROW_W-1:0]    wr_row,
    input  logic [2*N_IN-1:0]   wr_and,
    input  logic [N_OUT-1:0]    wr_or,
    input  logic [N_IN-1:0]     in_vec,
    output logic [N_OUT-1:0]    f_out
);
    logic [N_TERM-1:0][2*N_IN-1:0] and_pers;
    logic [N_TERM-1:0][N_OUT-1:0]  or_pers;
    logic [N_TERM-1:0]             term_vec;

    sop_pers_store #(
        .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .ROW_W(ROW_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
        .wr_and(wr_and), .wr_or(wr_or),
        .and_pers(and_pers), .or_pers(or_pers)
    );

    sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .in_vec(in_vec), .and_pers(and_pers), .term_vec(term_vec)
    );

    sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .term_vec(term_vec), .or_pers(or_pers), .f_out(f_out)
    );

endmodule

// File: rtl/sop_logic_array_chk.sv
module sop_logic_array_chk #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4,
    parameter int ROW_W  = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ROW_W-1:0]              wr_row,
    input logic [N_IN-1:0]               in_vec,
    input logic [N_OUT-1:0]              f_out,
    input logic [N_TERM-1:0][2*N_IN-1:0] and_pers,
    input logic [N_TERM-1:0][N_OUT-1:0]  or_pers,
    input logic [N_TERM-1:0]             term_vec
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (f_out == '0));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $stable(in_vec)) |-> $stable(f_out));

    // R7
    oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && ({1'b0, $past(wr_row)} >= (ROW_W+1)'(N_TERM))
         && $stable(in_vec)) |-> $stable(f_out));

    for (genvar t = 0; t < N_TERM; t++) begin : g_tchk
        logic killed;
        always_comb begin
            killed = 1'b0;
            for (int i = 0; i < N_IN; i++) begin
                killed = killed | (and_pers[t][2*i +: 2] == 2'b11);
            end
        end

        // R3
        open_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (and_pers[t] == '0) |-> term_vec[t]);

        // R2
        kill_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
            killed |-> !term_vec[t]);

        // R5
        fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
            term_vec[t] |-> ((f_out & or_pers[t]) == or_pers[t]));
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_ochk
        logic [N_TERM-1:0] col;
        always_comb begin
            for (int t = 0; t < N_TERM; t++) col[t] = or_pers[t][k];
        end

        // R4
        empty_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (col == '0) |-> !f_out[k]);
    end

endmodule

bind sop_logic_array sop_logic_array_chk #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .ROW_W(ROW_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .in_vec(in_vec), .f_out(f_out), .and_pers(and_pers),
    .or_pers(or_pers), .term_vec(term_vec)
);

// File: tb/sop_logic_array_tb.sv
module sop_logic_array_tb;
    localparam int N_IN   = 3;
    localparam int N_TERM = 5;
    localparam int N_OUT  = 4;
    localparam int ROW_W  = 3;
    localparam int AW     = 2 * N_IN;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [ROW_W-1:0] wr_row = '0;
    logic [AW-1:0]    wr_and = '0;
    logic [N_OUT-1:0] wr_or = '0;
    logic [N_IN-1:0]  in_vec = '0;
    logic [N_OUT-1:0] f_out;

    int n_chk = 0;
    int n_err = 0;

    logic [AW-1:0]    m_and [N_TERM];
    logic [N_OUT-1:0] m_or  [N_TERM];

    always #10 clk = ~clk;

    sop_logic_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
        .wr_and(wr_and), .wr_or(wr_or), .in_vec(in_vec), .f_out(f_out)
    );

    function automatic logic [N_OUT-1:0] model(input logic [N_IN-1:0] x);
        logic [N_OUT-1:0] r = '0;
        for (int t = 0; t < N_TERM; t++) begin
            logic p = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                case (m_and[t][2*i +: 2])
                    2'b00: p = p;
                    2'b01: p = p & ~x[i];
                    2'b10: p = p & x[i];
                    default: p = 1'b0;
                endcase
            end
            if (p) r = r | m_or[t];
        end
        return r;
    endfunction

    function automatic logic [N_OUT-1:0] golden(input logic [N_IN-1:0] x);
        logic a = x[0], b = x[1], c = x[2];
        return {(~b & c) | a, (~b & ~c) | (a & b), (a & ~c) | (a & b), a | (~b & ~c)};
    endfunction

    task automatic chk(input string req, input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b in=%b", req, act, exp, in_vec);
        end
    endtask

    task automatic put_row(input int r, input logic [AW-1:0] a, input logic [N_OUT-1:0] o);
        @(negedge clk);
        wr_en = 1'b1; wr_row = ROW_W'(r); wr_and = a; wr_or = o;
        @(negedge clk);
        wr_en = 1'b0;
        if (r < N_TERM) begin m_and[r] = a; m_or[r] = o; end
    endtask

    task automatic sweep(input string req);
        for (int v = 0; v < (1 << N_IN); v++) begin
            in_vec = N_IN'(v); #1;
            chk(req, f_out, model(in_vec));
        end
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        int dummy;
        dummy = $urandom(32'h5A17);
        for (int t = 0; t < N_TERM; t++) begin m_and[t] = '0; m_or[t] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all outputs zero after reset
        for (int v = 0; v < (1 << N_IN); v++) begin
            in_vec = N_IN'(v); #1; chk("R1", f_out, '0);
        end

        // R6: write visible only after the edge; R3 open term is true
        @(negedge clk);
        in_vec = '0;
        wr_en = 1'b1; wr_row = 3'd0; wr_and = '0; wr_or = 4'b0001;
        #1 chk("R6 before edge", f_out, 4'b0000);
        @(posedge clk); #1;
        chk("R6 after edge", f_out, 4'b0001);
        @(negedge clk); wr_en = 1'b0;
        m_and[0] = '0; m_or[0] = 4'b0001;
        sweep("R3");

        // R2: code 11 forces the term low
        put_row(0, 6'b11_00_00, 4'b0001);
        sweep("R2 kill");
        // R2: A true, B complemented -> A & ~B on F0
        put_row(0, 6'b00_01_10, 4'b0001);
        for (int v = 0; v < 8; v++) begin
            in_vec = 3'(v); #1;
            chk("R2 literal", f_out, {3'b000, in_vec[0] & ~in_vec[1]});
        end

        // R7: out-of-range rows ignored
        put_row(6, 6'b00_00_00, 4'b1111);
        put_row(5, 6'b00_00_00, 4'b1111);
        sweep("R7");

        // R6: wr_en low holds the personality
        @(negedge clk);
        wr_row = 3'd1; wr_and = '0; wr_or = 4'b1111;
        repeat (2) @(negedge clk);
        sweep("R6 hold");

        // R4: outputs without a connected term stay low
        in_vec = 3'b001; #1;
        chk("R4 empty column", f_out & 4'b1110, 4'b0000);

        // R8: shared-term example
        put_row(0, 6'b00_10_10, 4'b0110);
        put_row(1, 6'b10_01_00, 4'b1000);
        put_row(2, 6'b01_00_10, 4'b0010);
        put_row(3, 6'b01_01_00, 4'b0101);
        put_row(4, 6'b00_00_10, 4'b1001);
        for (int v = 0; v < 8; v++) begin
            in_vec = 3'(v); #1; chk("R8", f_out, golden(in_vec));
        end
        // R5: AB alone also raises F1 and F2; A raises F0 and F3
        in_vec = 3'b011; #1; chk("R5", f_out, 4'b1111);

        // R9: input change between edges
        @(posedge clk); #5;
        in_vec = 3'b110; #1; chk("R9", f_out, golden(3'b110));
        in_vec = 3'b000; #1; chk("R9", f_out, golden(3'b000));

        // R4 R5 R6 R7: random personalities
        for (int n = 0; n < 300; n++) begin
            int r;
            r = $urandom_range(0, 7);
            put_row(r, AW'($urandom), N_OUT'($urandom));
            in_vec = N_IN'($urandom); #1;
            chk("R4 random", f_out, model(in_vec));
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule